// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Driver

This block turns the interrupt requests of two conversion queues into line activity on a shared 8-bit interrupt bus. Software gives each queue one of 32 request levels through a 16-bit configuration register. The bus carries only eight lines, so the 32 levels are split across four time slots. A plain 2-bit slot selector names the current slot, and each slot holds a group of eight consecutive levels.

A queue whose request flag is set drives exactly one line, and only while the slot selector names the slot that holds its level. The block has no priority logic. When both queues request, their lines are ORed together, so two queues on the same level share one line. The output is registered on the bus clock. The configuration port has a single write strobe and a read-data bus that always shows the stored register. All of its pins are plain control pins with no handshake.

Top module: `irq_slot_driver`

## Requirements
- R1: After reset the configuration register reads 0x0000 and irq_out is 0x00.
- R2: A write with cfg_we high stores the queue 1 level from cfg_wdata[15:11] and the queue 2 level from cfg_wdata[10:6]. These fields read back in the same positions from the next cycle onward. Level code 5'b00000 is level 0 and 5'b11111 is level 31.
- R3: cfg_rdata[5:0] always reads zero, and any value written to those bits has no effect.
- R4: A requesting queue with level L drives irq_out bit L[2:0] only when L[4:3] equals slot_sel: 00 carries levels 7..0, 01 carries 15..8, 10 carries 23..16 and 11 carries 31..24. In any other slot it drives nothing.
- R5: A queue whose request flag (q_req[0] for queue 1, q_req[1] for queue 2) is low drives no line. With both flags low, irq_out is 0x00.
- R6: With both queues requesting, irq_out is the bitwise OR of the two contributions. Equal levels therefore assert a single line, and there is no priority between the queues.
- R7: irq_out is registered. It reflects slot_sel, q_req and the stored levels of the previous cycle, so a write in the same cycle as a request does not change the line driven for that request.
- R8: The configuration register holds its value in every cycle in which cfg_we is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_sel | input | 2 | Current time slot of the interrupt bus |
| q_req | input | 2 | Request flags, bit 0 for queue 1 and bit 1 for queue 2 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Stored configuration register |
| irq_out | output | 8 | Interrupt lines for the slot sampled in the previous cycle |

## Verification
A register write and a request that decodes the level being replaced can fall in the same cycle. The bench provokes this directly by rewriting queue 1's level to 0 while it requests at level 31 in slot 3. It then expects line 7 in the following cycle, and line 0 only one cycle after that. The random phase also mixes writes with requests in about a quarter of its cycles, and a reference model judges each output against the level held before the write.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned DEF_NQ    = 2;
  localparam int unsigned DEF_LVL_W = 5;
  localparam int unsigned DEF_BUS_W = 8;
  localparam int unsigned DEF_CFG_W = 16;

  // Position of the most significant bit of a queue's level field.
  function automatic int unsigned field_hi(int unsigned cfg_w, int unsigned lvl_w,
                                           int unsigned q);
    return cfg_w - 1 - q * lvl_w;
  endfunction
endpackage

// File: rtl/irqd_cfg_reg.sv
module irqd_cfg_reg
  import irqd_pkg::*;
#(
  parameter int unsigned NQ    = DEF_NQ,
  parameter int unsigned LVL_W = DEF_LVL_W,
  parameter int unsigned CFG_W = DEF_CFG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [CFG_W-1:0]      wdata,
  output logic [CFG_W-1:0]      rdata,
  output logic [NQ*LVL_W-1:0]   levels
);
  logic [CFG_W-1:0] field_mask;
  logic [CFG_W-1:0] cfg_q;

  // One mask slice per level field; every other bit stays zero.
  for (genvar q = 0; q < NQ; q++) begin : g_field
    localparam int unsigned HI = field_hi(CFG_W, LVL_W, q);
    assign field_mask[HI -: LVL_W]      = '1;
    assign levels[q*LVL_W +: LVL_W]     = cfg_q[HI -: LVL_W];
  end
  if (CFG_W > NQ * LVL_W) begin : g_rsv
    assign field_mask[CFG_W-NQ*LVL_W-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wdata & field_mask;
  end

  assign rdata = cfg_q;
endmodule

// File: rtl/irqd_level_decode.sv
module irqd_level_decode
  import irqd_pkg::*;
#(
  parameter int unsigned LVL_W = DEF_LVL_W,
  parameter int unsigned BUS_W = DEF_BUS_W
) (
  input  logic                       req,
  input  logic [LVL_W-1:0]           level,
  input  logic [LVL_W-$clog2(BUS_W)-1:0] slot,
  output logic [BUS_W-1:0]           lines
);
  localparam int unsigned LINE_W = $clog2(BUS_W);

  logic slot_hit;
  assign slot_hit = (level[LVL_W-1:LINE_W] == slot);

  always_comb begin
    lines = '0;
    if (req && slot_hit) lines[level[LINE_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/irq_slot_driver.sv
module irq_slot_driver
  import irqd_pkg::*;
#(
  parameter int unsigned NQ    = DEF_NQ,
  parameter int unsigned LVL_W = DEF_LVL_W,
  parameter int unsigned BUS_W = DEF_BUS_W,
  parameter int unsigned CFG_W = DEF_CFG_W,
  localparam int unsigned SLOT_W = LVL_W - $clog2(BUS_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic [NQ-1:0]     q_req,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [BUS_W-1:0]  irq_out
);
  logic [NQ*LVL_W-1:0] levels;
  logic [BUS_W-1:0]    contrib [NQ];
  logic [BUS_W-1:0]    irq_d;

  irqd_cfg_reg #(.NQ(NQ), .LVL_W(LVL_W), .CFG_W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .levels (levels)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    irqd_level_decode #(.LVL_W(LVL_W), .BUS_W(BUS_W)) u_dec (
      .req   (q_req[q]),
      .level (levels[q*LVL_W +: LVL_W]),
      .slot  (slot_sel),
      .lines (contrib[q])
    );
  end

  // Wired-OR merge: no priority between queues.
  always_comb begin
    irq_d = '0;
    for (int q = 0; q < NQ; q++) irq_d = irq_d | contrib[q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_d;
  end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  slot_sel,
  input logic [1:0]  q_req,
  input logic        cfg_we,
  input logic [15:0] cfg_wdata,
  input logic [15:0] cfg_rdata,
  input logic [7:0]  irq_out
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[5:0] == 6'd0); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[15:6] == $past(cfg_wdata[15:6])); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata)); // R8

  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (q_req == 2'b00) |=> irq_out == 8'h00); // R5

  AST_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= 2); // R6

  AST_Q1_SLOT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_req == 2'b01) |=> irq_out == (($past(cfg_rdata[15:14]) == $past(slot_sel))
                                     ? (8'h01 << $past(cfg_rdata[13:11])) : 8'h00)); // R4
endmodule

bind irq_slot_driver irqd_checker u_irqd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_sel  (slot_sel),
  .q_req     (q_req),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .irq_out   (irq_out)
);

// File: tb/irq_slot_driver_tb.sv
module irq_slot_driver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  slot_sel = '0;
  logic [1:0]  q_req = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [7:0]  irq_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] mreg = '0;
  bit done = 1'b0;

  localparam logic [15:0] FIELD_MASK = 16'hFFC0;

  always #4 clk = ~clk; // 125 MHz

  irq_slot_driver u_dut (
    .clk(clk), .rst_n(rst_n), .slot_sel(slot_sel), .q_req(q_req),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] exp_irq(logic [15:0] r, logic [1:0] sl, logic [1:0] rq);
    logic [7:0] e = '0;
    logic [4:0] l1 = r[15:11];
    logic [4:0] l2 = r[10:6];
    if (rq[0] && l1[4:3] == sl) e[l1[2:0]] = 1'b1;
    if (rq[1] && l2[4:3] == sl) e[l2[2:0]] = 1'b1;
    return e;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at a falling edge, judge at the next falling edge.
  task automatic cycle(logic we, logic [15:0] wd, logic [1:0] sl, logic [1:0] rq, string itag);
    logic [7:0] e;
    string t;
    cfg_we = we; cfg_wdata = wd; slot_sel = sl; q_req = rq;
    e = exp_irq(mreg, sl, rq);
    if (we) mreg = wd & FIELD_MASK;
    @(negedge clk);
    if (itag != "") t = itag;
    else if (rq == 2'b00) t = "R5";
    else if (rq == 2'b11) t = "R6";
    else t = "R4";
    check({t, " irq"}, {8'h00, irq_out}, {8'h00, e});
    check(we ? "R2 rdata" : "R8 rdata", cfg_rdata, mreg);
    check("R3 reserved", {10'd0, cfg_rdata[5:0]}, 16'd0);
  endtask

  function automatic logic [15:0] cfg(logic [4:0] a, logic [4:0] b);
    return {a, b, 6'd0};
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", cfg_rdata, 16'h0000);
    check("R1 irq after reset", {8'h00, irq_out}, 16'h0000);
    rst_n = 1'b1;

    cycle(1'b1, cfg(5'd9, 5'd9), 2'd0, 2'b00, "");
    cycle(1'b0, '0, 2'd1, 2'b11, "R6 same level");      // both on line 1
    cycle(1'b1, cfg(5'd3, 5'd5), 2'd0, 2'b00, "");
    cycle(1'b0, '0, 2'd0, 2'b11, "R6 or of two");        // lines 3 and 5
    cycle(1'b0, '0, 2'd0, 2'b00, "R5 no request");
    cycle(1'b1, cfg(5'd31, 5'd0), 2'd3, 2'b00, "");
    cycle(1'b0, '0, 2'd3, 2'b01, "R4 level 31");
    cycle(1'b0, '0, 2'd0, 2'b10, "R4 level 0");
    cycle(1'b0, '0, 2'd2, 2'b11, "R4 wrong slot");
    cycle(1'b1, 16'hFFFF, 2'd0, 2'b00, "");              // R3: reads 0xFFC0
    cycle(1'b1, cfg(5'd31, 5'd0), 2'd0, 2'b00, "");
    cycle(1'b1, cfg(5'd0, 5'd0), 2'd3, 2'b01, "R7 write with request");
    cycle(1'b0, '0, 2'd0, 2'b01, "R7 new level next cycle");

    void'($urandom(32'd2718));
    for (int i = 0; i < 3000; i++) begin
      logic we;
      we = ($urandom % 4) == 0;
      cycle(we, 16'($urandom), 2'($urandom), 2'($urandom), "");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule